// File: doc/BRIEF.md
# SPI Frame Register-Access Bridge

This block lives in the system clock domain beside a serial-clocked SPI slave shift-register core. The core raises a busy flag on the first shift edge of a frame and drops it when slave select deasserts. At that point it also presents the received parallel word. The bridge passes busy through a two-flop synchronizer and detects its falling edge. It then captures the received word and treats it as a command to a bank of eight small control registers. No logic here runs on the serial clock, which is slower than the system clock and stops between frames.

Each command is one 8-bit word. A write changes the low nibble of one register. A read loads that register's value into the reply word, and the core shifts the reply out during the following frame. Read data therefore always lags its command by one frame. The reply is settled a few system clocks after busy falls, well before the core can latch it at the next frame's first shift edge. The bridge gives a one-cycle pulse for each completed frame. It also keeps a sticky error flag, which is set when busy comes back before the reply for the previous frame has been loaded.

Top module: `spi_frame_bridge`

## Requirements
- R1: Synchronous active-high reset clears the reply word to 8'h00, the frame pulse, the error flag, all eight registers and the synchronizer flops.
- R2: Take edge n as the first rising clock edge that samples busy low after a frame. The frame pulse is high for exactly one cycle, starting at edge n+2. It never pulses unless busy was sampled low three edges before.
- R3: The received word is captured at edge n+2 and decoded as follows. Bit 7 is the first serial bit and marks a read when 1. Bits 6:4 give the register address, 0 to 7. Bits 3:0 give the write data. Changes on the received word after edge n+2 have no effect.
- R4: A write sets the low nibble of the addressed register to bits 3:0, leaves its high nibble 0, and leaves the other seven registers unchanged.
- R5: A read decoded in frame k places the addressed register's value on the reply word at edge n+3, so it is shifted out in frame k+1.
- R6: After a write command the reply word for the next frame is 8'h00.
- R7: The reply word changes only at the edge that follows a frame pulse, and it stays stable through the whole of the next frame.
- R8: The error flag is set when busy is sampled high again at edge n+1, which is before the reply update. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| busyAsync | input | 1 | Busy flag from the serial core, asynchronous to clk |
| rxWord | input | 8 | Received parallel word from the serial core |
| replyWord | output | 8 | Word for the core to shift out in the next frame |
| framePulse | output | 1 | One-cycle pulse per completed frame |
| errFlag | output | 1 | Sticky flag for busy returning before the reply update |

## Verification
Results follow fixed cycle counts from edge n, the first edge that samples busy low. The frame pulse is due after edge n+2 and is gone after edge n+3. The reply word is due after edge n+3. The error flag is due after edge n+3 when busy was low for only one sample. The bench drives busy on falling clock edges and counts rising edges from that point. It samples one time unit after edges n+2 and n+3, so it sees both the old and the new reply. It changes the received word just after edge n+2 to show that the capture took place at that edge. The vector table covers writes and reads across consecutive frames, and directed tests cover the short-busy error case and its stickiness, then reset.

// File: rtl/spi_frame_bridge_pkg.sv
package spi_frame_bridge_pkg;

  typedef struct packed {
    logic capture;
    logic exec;
  } bridgeStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_LOAD   = 2'd2
  } bridgeState_t;

endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_bridge_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           busySync,
  output bridgeStrobes_t strobes,
  output logic           framePulse,
  output logic           errFlag
);
  bridgeState_t state, stateNext;
  logic fallSeen;

  // falling edge of synchronized busy: active frame, busy now low
  assign fallSeen = (state == ST_ACTIVE) && !busySync;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (busySync) stateNext = ST_ACTIVE;
      ST_ACTIVE: if (!busySync) stateNext = ST_LOAD;
      ST_LOAD:   stateNext = busySync ? ST_ACTIVE : ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.capture = fallSeen;
    strobes.exec    = (state == ST_LOAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      framePulse <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      state      <= stateNext;
      framePulse <= fallSeen;
      if (state == ST_LOAD && busySync) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_frame_datapath.sv
module spi_frame_datapath
  import spi_frame_bridge_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  bridgeStrobes_t    strobes,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] replyWord
);
  localparam int NUM_REGS = 2 ** ADDR_W;
  localparam int RW_BIT   = WORD_W - 1;
  localparam int ADDR_LSB = RW_BIT - ADDR_W;
  localparam int PAD_W    = WORD_W - DATA_W;

  logic [WORD_W-1:0] cmdReg;
  logic [WORD_W-1:0] regBank [NUM_REGS];
  logic              cmdRead;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;

  assign cmdRead = cmdReg[RW_BIT];
  assign cmdAddr = cmdReg[ADDR_LSB +: ADDR_W];
  assign cmdData = cmdReg[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                  cmdReg <= '0;
    else if (strobes.capture) cmdReg <= rxWord;
  end

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regBank[i] <= '0;
        else if (strobes.exec && !cmdRead && cmdAddr == ADDR_W'(i))
          regBank[i] <= {{PAD_W{1'b0}}, cmdData};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)               replyWord <= '0;
    else if (strobes.exec) replyWord <= cmdRead ? regBank[cmdAddr] : '0;
  end
endmodule

// File: rtl/spi_frame_bridge.sv
module spi_frame_bridge
  import spi_frame_bridge_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busyAsync,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] replyWord,
  output logic              framePulse,
  output logic              errFlag
);
  logic           busySync;
  bridgeStrobes_t strobes;

  spi_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(busyAsync), .dout(busySync)
  );

  spi_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .busySync(busySync), .strobes(strobes),
    .framePulse(framePulse), .errFlag(errFlag)
  );

  spi_frame_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .rxWord(rxWord), .replyWord(replyWord)
  );
endmodule

// File: rtl/spi_frame_bridge_chk.sv
module spi_frame_bridge_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busyAsync,
  input logic [WORD_W-1:0] replyWord,
  input logic              framePulse,
  input logic              errFlag
);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    framePulse |=> !framePulse);

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    framePulse |-> ($past(busyAsync, 3) == 1'b0));

  // R7
  reply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(framePulse) |-> $stable(replyWord));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(errFlag) |-> $past(framePulse));
endmodule

bind spi_frame_bridge spi_frame_bridge_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .busyAsync(busyAsync), .replyWord(replyWord),
  .framePulse(framePulse), .errFlag(errFlag)
);

// File: tb/spi_frame_bridge_bench.sv
module spi_frame_bridge_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busyAsync = 1'b0;
  logic [7:0] rxWord = 8'h00;
  logic [7:0] replyWord;
  logic       framePulse;
  logic       errFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  spi_frame_bridge u_spi_frame_bridge (
    .clk(clk), .rst(rst), .busyAsync(busyAsync), .rxWord(rxWord),
    .replyWord(replyWord), .framePulse(framePulse), .errFlag(errFlag)
  );

  // {command word, expected reply after this frame}
  localparam int NVEC = 10;
  localparam logic [15:0] VECS [NVEC] = '{
    {8'h35, 8'h00},  // write r3 <= 5
    {8'h0F, 8'h00},  // write r0 <= F
    {8'hB0, 8'h05},  // read r3
    {8'h80, 8'h0F},  // read r0
    {8'h7A, 8'h00},  // write r7 <= A
    {8'hF0, 8'h0A},  // read r7
    {8'h90, 8'h00},  // read r1 (never written)
    {8'h3C, 8'h00},  // write r3 <= C
    {8'hB0, 8'h0C},  // read r3
    {8'h80, 8'h0F}   // read r0 unchanged by writes elsewhere
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic [7:0] word, input logic [7:0] expReply);
    logic [7:0] prevReply;
    @(negedge clk);
    prevReply = replyWord;
    busyAsync = 1'b1;
    rxWord    = ~word;
    repeat (3) @(negedge clk);
    check("R7 reply held during frame", replyWord, prevReply);
    rxWord = word;
    repeat (2) @(negedge clk);
    busyAsync = 1'b0;            // edge n is the next posedge
    repeat (3) @(posedge clk);   // n, n+1, n+2
    #1;
    check("R2 pulse at n+2", {7'd0, framePulse}, 8'h01);
    check("R5 reply not yet updated", replyWord, prevReply);
    rxWord = ~word;              // R3: late change must be ignored
    @(posedge clk);              // n+3
    #1;
    check("R2 pulse one cycle", {7'd0, framePulse}, 8'h00);
    check("R4 R5 R6 reply word", replyWord, expReply);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 reply at reset", replyWord, 8'h00);
    check("R1 pulse at reset", {7'd0, framePulse}, 8'h00);
    check("R1 err at reset", {7'd0, errFlag}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) runFrame(VECS[i][15:8], VECS[i][7:0]);

    // R8: busy low for one sample only
    check("R8 err clear before", {7'd0, errFlag}, 8'h00);
    @(negedge clk);
    busyAsync = 1'b1;
    rxWord = 8'hB0;
    repeat (4) @(negedge clk);
    busyAsync = 1'b0;
    @(negedge clk);
    busyAsync = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 err set on short busy low", {7'd0, errFlag}, 8'h01);
    check("R8 reply still loaded", replyWord, 8'h0C);
    busyAsync = 1'b0;
    repeat (6) @(negedge clk);
    runFrame(8'h80, 8'h0F);
    check("R8 err sticky", {7'd0, errFlag}, 8'h01);

    // R1: reset clears registers and flags
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 err cleared", {7'd0, errFlag}, 8'h00);
    check("R1 reply cleared", replyWord, 8'h00);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    runFrame(8'hB0, 8'h00);
    runFrame(8'h80, 8'h00);  // R1: r0 and r3 read back zero after reset

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule